// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block lets a host on a simple memory-mapped bus reach a larger internal register space through a narrow window of three registers. The first register selects an internal address, the second carries data to or from that address, and the third holds the error-response enable. An internal address takes effect only after the host has written it twice in a row with the same low 16 bits. After that, one write to the data register stores a word at the selected internal register. Reads run through a one-deep pipeline: the first data read after the address is set returns whatever the bridge last fetched, and the second read returns the selected register.

The window is replicated by parameter. With two windows, the second one sits 0x10 above the first, and each window has its own commit state, read buffer, enable bit and internal register space. A small internal register file with a one-cycle read latency sits behind each window so that the bridge can be exercised on its own.

A data access made while no address is committed has no effect inside the block and reads back zero. When the enable bit is set, the bridge also raises an error response for that access.

Top module: `idx_bridge`

## Requirements
- R1: After reset, every window register reads 0, no error is signalled, no address is committed, every internal register holds 0 and every read buffer holds 0.
- R2: Only bits 15:0 of an address-register write (offset 0x0) form the internal address. While an address is committed, reading the address register returns that address zero-extended; while none is committed, it reads 0.
- R3: An address commits when the host writes it to the address register and the very next window access is a second address write with equal low 16 bits. A second write with different bits, or any other access to that window in between, starts a new pair.
- R4: An address write made while an address is committed always withdraws the commit, even when the value is the same, and opens a new pair.
- R5: With an address committed, a single data-register write (offset 0x4) stores the full 32-bit word in the internal register at that address.
- R6: With an address committed, a data-register read returns the value of the most recent internal fetch of that window (0 after reset) and starts a fetch of the committed address. A read in the next or any later cycle therefore returns the addressed register. Address writes and data writes never refresh the buffer.
- R7: A data access made while no address is committed does not change any internal register and reads 0. The access raises the error response exactly when the enable bit is 1.
- R8: The control register (offset 0x8) stores write-data bit 15 as the error-response enable. Reads return that bit at position 15 and 0 in every other bit. Offset 0xC reads 0.
- R9: Read data and the error response appear in the cycle after the access. In any cycle that does not follow a read, host_rdata is 0.
- R10: Window w decodes host_addr[4] == w and has its own commit state, buffer, enable bit and register space. Accesses to one window never change another, and at most one internal strobe is active per cycle.
- R11: Each internal register file holds RF_DEPTH words. An internal address at or above RF_DEPTH reads 0 and ignores writes, and does not alias onto a lower register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW (5) | Host byte address; bit 4 selects the window, bits 3:2 select the register |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access; a write in the same cycle takes precedence |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Read data, valid in the cycle after the read |
| host_err | output | 1 | Error response, pulsed in the cycle after a failed data access |

## Verification
The bench builds the bridge with two windows and 16-word register files. With two windows it can check that commit state, buffers, enable bits and register spaces stay separate between windows. With 16 words it can commit addresses above the last register, and so reach the out-of-range and no-aliasing cases. Back-to-back data reads one cycle apart exercise the path where a fetch completes in the same cycle as the next read. Interrupted, mismatched and third address writes cover every way a commit can fail or be withdrawn.

// File: rtl/idxb_pkg.sv
`timescale 1ns/1ps
package idxb_pkg;

   // register select inside one window, decoded from host_addr[3:2]
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } win_sel_e;

   // each window spans 16 bytes
   localparam int WIN_SPAN_LOG2 = 4;
   // control bit enabling the error response
   localparam int ERR_EN_BIT    = 15;

endpackage

// File: rtl/idxb_commit.sv
`timescale 1ns/1ps
module idxb_commit #(
   parameter int IAW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           addr_wr,
   input  logic           other_acc,
   input  logic [IAW-1:0] addr_val,
   output logic           committed,
   output logic [IAW-1:0] commit_addr
);

   logic [IAW-1:0] pend_q;
   logic           pend_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= '0;
         pend_v_q    <= 1'b0;
         committed   <= 1'b0;
         commit_addr <= '0;
      end else if (addr_wr) begin
         if (pend_v_q && (addr_val == pend_q)) begin
            committed   <= 1'b1;
            commit_addr <= addr_val;
            pend_v_q    <= 1'b0;
         end else begin
            pend_q    <= addr_val;
            pend_v_q  <= 1'b1;
            committed <= 1'b0;
         end
      end else if (other_acc) begin
         pend_v_q <= 1'b0;
      end
   end

endmodule

// File: rtl/idxb_rdpipe.sv
`timescale 1ns/1ps
module idxb_rdpipe #(
   parameter int DW     = 32,
   parameter bit BYPASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          resp_valid,
   input  logic [DW-1:0] resp_data,
   output logic [DW-1:0] cur_value
);

   logic [DW-1:0] buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          buf_q <= '0;
      else if (resp_valid) buf_q <= resp_data;
   end

   generate
      if (BYPASS) begin : g_bypass
         assign cur_value = resp_valid ? resp_data : buf_q;
      end else begin : g_plain
         assign cur_value = buf_q;
      end
   endgenerate

endmodule

// File: rtl/idxb_regfile.sv
`timescale 1ns/1ps
module idxb_regfile #(
   parameter int DW    = 32,
   parameter int IAW   = 16,
   parameter int DEPTH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IAW-1:0] iaddr,
   input  logic           iwr,
   input  logic           ird,
   input  logic [DW-1:0]  iwdata,
   output logic [DW-1:0]  rdata_q,
   output logic           rvalid_q
);

   localparam int         IDXW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IAW:0] DEPTH_V = (IAW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 4096) begin : g_bad_depth
         $error("idxb_regfile: DEPTH out of range");
      end
      if (IDXW > IAW) begin : g_bad_iaw
         $error("idxb_regfile: DEPTH exceeds internal address space");
      end
   endgenerate

   logic [DW-1:0]   mem [DEPTH];
   logic            in_range;
   logic [IDXW-1:0] idx;

   assign in_range = ({1'b0, iaddr} < DEPTH_V);
   assign idx      = iaddr[IDXW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= ird;
         if (ird) rdata_q <= in_range ? mem[idx] : '0;
         if (iwr && in_range) mem[idx] <= iwdata;
      end
   end

endmodule

// File: rtl/idxb_window.sv
`timescale 1ns/1ps
module idxb_window
   import idxb_pkg::*;
#(
   parameter int DW  = 32,
   parameter int IAW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel,
   input  win_sel_e       reg_sel,
   input  logic           wr,
   input  logic           rd,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata_q,
   output logic           err_q,
   output logic [IAW-1:0] iaddr,
   output logic           iwr,
   output logic           ird,
   output logic [DW-1:0]  iwdata,
   input  logic [DW-1:0]  irdata,
   input  logic           ivalid
);

   logic           eff_rd, addr_wr, other_acc, data_acc, ctrl_wr;
   logic           committed;
   logic [IAW-1:0] commit_addr;
   logic [DW-1:0]  buf_value;
   logic [DW-1:0]  rd_mux;
   logic           ctrl_q;

   assign eff_rd    = rd & ~wr;
   assign addr_wr   = sel & wr & (reg_sel == SEL_ADDR);
   assign other_acc = sel & (eff_rd | (wr & (reg_sel != SEL_ADDR)));
   assign data_acc  = sel & (reg_sel == SEL_DATA) & (wr | rd);
   assign ctrl_wr   = sel & wr & (reg_sel == SEL_CTRL);

   idxb_commit #(.IAW(IAW)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_wr    (addr_wr),
      .other_acc  (other_acc),
      .addr_val   (wdata[IAW-1:0]),
      .committed  (committed),
      .commit_addr(commit_addr)
   );

   assign iaddr  = commit_addr;
   assign iwdata = wdata;
   assign iwr    = data_acc & wr & committed;
   assign ird    = data_acc & eff_rd & committed;

   idxb_rdpipe #(.DW(DW), .BYPASS(1'b1)) u_rdpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .resp_valid(ivalid),
      .resp_data (irdata),
      .cur_value (buf_value)
   );

   always_comb begin
      rd_mux = '0;
      case (reg_sel)
         SEL_ADDR: if (committed) rd_mux = DW'(commit_addr);
         SEL_DATA: if (committed) rd_mux = buf_value;
         SEL_CTRL: rd_mux[ERR_EN_BIT] = ctrl_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= 1'b0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= wdata[ERR_EN_BIT];
         rdata_q <= (sel & eff_rd) ? rd_mux : '0;
         err_q   <= data_acc & ~committed & ctrl_q;
      end
   end

endmodule

// File: rtl/idx_bridge.sv
`timescale 1ns/1ps
module idx_bridge
   import idxb_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int HOST_AW  = 5,
   parameter int DW       = 32,
   parameter int IAW      = 16,
   parameter int RF_DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DW-1:0]      host_wdata,
   output logic [DW-1:0]      host_rdata,
   output logic               host_err
);

   localparam int WSEL_W = HOST_AW - WIN_SPAN_LOG2;

   generate
      if (HOST_AW <= WIN_SPAN_LOG2) begin : g_bad_aw
         $error("idx_bridge: HOST_AW leaves no window select bits");
      end
      if (NUM_WIN < 1 || NUM_WIN > (1 << (HOST_AW - WIN_SPAN_LOG2))) begin : g_bad_nw
         $error("idx_bridge: NUM_WIN does not fit the host address");
      end
      if (DW < IAW || DW <= ERR_EN_BIT) begin : g_bad_dw
         $error("idx_bridge: DW too narrow");
      end
   endgenerate

   logic [WSEL_W-1:0]  win_idx;
   win_sel_e           reg_sel;
   logic [1:0]         unused_lo;

   assign win_idx   = host_addr[HOST_AW-1:WIN_SPAN_LOG2];
   assign reg_sel   = win_sel_e'(host_addr[3:2]);
   assign unused_lo = host_addr[1:0];

   logic [DW-1:0]      win_rdata [NUM_WIN];
   logic [NUM_WIN-1:0] win_err;
   logic [NUM_WIN-1:0] win_iwr;
   logic [NUM_WIN-1:0] win_ird;
   logic [NUM_WIN-1:0] win_ivalid;
   logic [IAW-1:0]     win_iaddr  [NUM_WIN];
   logic [DW-1:0]      win_iwdata [NUM_WIN];
   logic [DW-1:0]      win_irdata [NUM_WIN];

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic sel;
         assign sel = (win_idx == WSEL_W'(w));

         idxb_window #(.DW(DW), .IAW(IAW)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .reg_sel(reg_sel),
            .wr     (host_wr),
            .rd     (host_rd),
            .wdata  (host_wdata),
            .rdata_q(win_rdata[w]),
            .err_q  (win_err[w]),
            .iaddr  (win_iaddr[w]),
            .iwr    (win_iwr[w]),
            .ird    (win_ird[w]),
            .iwdata (win_iwdata[w]),
            .irdata (win_irdata[w]),
            .ivalid (win_ivalid[w])
         );

         idxb_regfile #(.DW(DW), .IAW(IAW), .DEPTH(RF_DEPTH)) u_rf (
            .clk     (clk),
            .rst_n   (rst_n),
            .iaddr   (win_iaddr[w]),
            .iwr     (win_iwr[w]),
            .ird     (win_ird[w]),
            .iwdata  (win_iwdata[w]),
            .rdata_q (win_irdata[w]),
            .rvalid_q(win_ivalid[w])
         );
      end
   endgenerate

   always_comb begin
      host_rdata = '0;
      host_err   = 1'b0;
      for (int w = 0; w < NUM_WIN; w++) begin
         host_rdata = host_rdata | win_rdata[w];
         host_err   = host_err | win_err[w];
      end
   end

endmodule

// File: rtl/idxb_checker.sv
`timescale 1ns/1ps
module idxb_checker #(
   parameter int NUM_WIN = 2,
   parameter int HOST_AW = 5,
   parameter int DW      = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HOST_AW-1:0] host_addr,
   input logic               host_wr,
   input logic               host_rd,
   input logic [DW-1:0]      host_rdata,
   input logic               host_err,
   input logic [NUM_WIN-1:0] win_iwr,
   input logic [NUM_WIN-1:0] win_ird
);

   // R9: no read in the previous cycle means zero read data
   a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(host_rd) |-> (host_rdata == '0));

   // R7: an error response follows only a data-register access
   a_r7_err_after_data_acc: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> $past((host_addr[3:2] == 2'd1) && (host_rd || host_wr)));

   // R3: an address-register write never draws an error
   a_r3_addr_wr_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      $past(host_wr && (host_addr[3:2] == 2'd0)) |-> !host_err);

   // R10: at most one internal strobe across all windows
   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_iwr, win_ird}));

   // R5: an internal write needs a host write
   a_r5_iwr_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
      (|win_iwr) |-> host_wr);

   // R6: an internal fetch needs a host read without a write
   a_r6_ird_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
      (|win_ird) |-> (host_rd && !host_wr));

endmodule

bind idx_bridge idxb_checker #(
   .NUM_WIN(NUM_WIN),
   .HOST_AW(HOST_AW),
   .DW     (DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_addr (host_addr),
   .host_wr   (host_wr),
   .host_rd   (host_rd),
   .host_rdata(host_rdata),
   .host_err  (host_err),
   .win_iwr   (win_iwr),
   .win_ird   (win_ird)
);

// File: tb/idx_bridge_tb.sv
`timescale 1ns/1ps
module idx_bridge_tb;

   localparam logic [4:0] A0 = 5'h00, D0 = 5'h04, C0 = 5'h08, X0 = 5'h0C;
   localparam logic [4:0] A1 = 5'h10, D1 = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_err;

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;
   logic acc_d = 1'b0;

   logic [31:0] q_dat [$];
   logic        q_err [$];
   string       q_tag [$];

   always #10 clk = ~clk;

   idx_bridge #(.NUM_WIN(2), .HOST_AW(5), .DW(32), .IAW(16), .RF_DEPTH(16)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_addr (host_addr),
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .host_err  (host_err)
   );

   always @(posedge clk) acc_d <= host_rd | host_wr;

   // monitor: result of the access driven one cycle earlier
   always @(negedge clk) begin
      if (acc_d && q_dat.size() > 0) begin
         logic [31:0] ed;
         logic        ee;
         string       tg;
         ed = q_dat.pop_front();
         ee = q_err.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (host_rdata !== ed || host_err !== ee) begin
            bad++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tg, host_rdata, host_err, ed, ee);
         end
      end
   end

   task automatic do_op(input logic w, input logic r, input logic [4:0] a,
                        input logic [31:0] d, input logic [31:0] ed,
                        input logic ee, input string tag);
      @(negedge clk);
      host_wr    = w;
      host_rd    = r;
      host_addr  = a;
      host_wdata = d;
      q_dat.push_back(ed);
      q_err.push_back(ee);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic ee, input string tag);
      do_op(1'b1, 1'b0, a, d, 32'h0, ee, tag);
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] ed, input logic ee, input string tag);
      do_op(1'b0, 1'b1, a, 32'h0, ed, ee, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      host_wr = 1'b0;
      host_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A0, 32'h0, 1'b0, "R1 addr reg after reset");
      rd(D0, 32'h0, 1'b0, "R1 data reg after reset");
      rd(C0, 32'h0, 1'b0, "R1 ctrl reg after reset");
      rd(X0, 32'h0, 1'b0, "R8 offset 0xC reads zero");
      // R7 uncommitted, errors disabled
      wr(D0, 32'h1234, 1'b0, "R7 uncommitted write no err when disabled");
      // R8 enable bit
      wr(C0, 32'hFFFF_FFFF, 1'b0, "R9 ctrl write returns zero");
      rd(C0, 32'h0000_8000, 1'b0, "R8 ctrl readback bit 15 only");
      // R7 with errors enabled
      rd(D0, 32'h0, 1'b1, "R7 uncommitted read errors");
      wr(D0, 32'h9999, 1'b1, "R7 uncommitted write errors");
      // R3 interrupted pair
      wr(A0, 32'h3, 1'b0, "R3 first addr write");
      rd(C0, 32'h0000_8000, 1'b0, "R3 interrupting access");
      wr(A0, 32'h3, 1'b0, "R3 addr write after break");
      rd(D0, 32'h0, 1'b1, "R3 interrupted pair not committed");
      // R3 mismatched pair
      wr(A0, 32'h3, 1'b0, "R3 pair a");
      wr(A0, 32'h4, 1'b0, "R3 pair mismatch");
      wr(A0, 32'h3, 1'b0, "R3 pair restart");
      rd(A0, 32'h0, 1'b0, "R3 mismatched pair not committed");
      // R2 commit using low 16 bits
      wr(A0, 32'hABCD_0002, 1'b0, "R2 addr write high bits a");
      wr(A0, 32'h5555_0002, 1'b0, "R2 addr write high bits b");
      rd(A0, 32'h0000_0002, 1'b0, "R2 committed address readback");
      // R5 / R6
      wr(D0, 32'hCAFE_F00D, 1'b0, "R5 data write committed");
      rd(D0, 32'h0, 1'b0, "R6 first read stale after reset");
      rd(D0, 32'hCAFE_F00D, 1'b0, "R6 second read fresh");
      wr(A0, 32'h5, 1'b0, "R3 commit 5 a");
      wr(A0, 32'h5, 1'b0, "R3 commit 5 b");
      wr(D0, 32'h5555_AAAA, 1'b0, "R5 write reg 5");
      rd(D0, 32'hCAFE_F00D, 1'b0, "R6 first read returns previous fetch");
      rd(D0, 32'h5555_AAAA, 1'b0, "R6 second read reg 5");
      // R4 third write withdraws
      wr(A0, 32'h5, 1'b0, "R4 third addr write");
      rd(D0, 32'h0, 1'b1, "R4 commit withdrawn");
      rd(A0, 32'h0, 1'b0, "R4 addr reads zero when withdrawn");
      // R6 re-address: first read stale
      wr(A0, 32'h2, 1'b0, "R6 commit 2 a");
      wr(A0, 32'h2, 1'b0, "R6 commit 2 b");
      rd(D0, 32'h5555_AAAA, 1'b0, "R6 stale after re-address");
      rd(D0, 32'hCAFE_F00D, 1'b0, "R6 fresh after re-address");
      // R11 out of range
      wr(A0, 32'h20, 1'b0, "R11 commit 0x20 a");
      wr(A0, 32'h20, 1'b0, "R11 commit 0x20 b");
      wr(D0, 32'h77, 1'b0, "R11 write beyond depth");
      rd(D0, 32'hCAFE_F00D, 1'b0, "R11 stale before out-of-range fetch");
      rd(D0, 32'h0, 1'b0, "R11 out-of-range reads zero");
      wr(A0, 32'h0, 1'b0, "R11 commit 0 a");
      wr(A0, 32'h0, 1'b0, "R11 commit 0 b");
      rd(D0, 32'h0, 1'b0, "R11 stale zero");
      rd(D0, 32'h0, 1'b0, "R11 reg 0 not aliased");
      // R10 second window
      rd(A1, 32'h0, 1'b0, "R10 window 1 uncommitted");
      rd(D1, 32'h0, 1'b0, "R10 window 1 own enable bit clear");
      wr(A1, 32'h2, 1'b0, "R10 w1 commit a");
      wr(A1, 32'h2, 1'b0, "R10 w1 commit b");
      wr(D1, 32'h1111, 1'b0, "R10 w1 write reg 2");
      rd(D1, 32'h0, 1'b0, "R10 w1 own buffer stale zero");
      rd(D1, 32'h1111, 1'b0, "R10 w1 reg 2");
      wr(A0, 32'h2, 1'b0, "R10 w0 commit 2 a");
      wr(A0, 32'h2, 1'b0, "R10 w0 commit 2 b");
      rd(D0, 32'h0, 1'b0, "R10 w0 stale");
      rd(D0, 32'hCAFE_F00D, 1'b0, "R10 w0 reg 2 untouched by w1");
      // R8 disable errors again
      wr(C0, 32'h0, 1'b0, "R8 clear enable");
      wr(A0, 32'h9, 1'b0, "R4 withdraw by new addr");
      rd(D0, 32'h0, 1'b0, "R8 no err when disabled");
      rd(C0, 32'h0, 1'b0, "R8 ctrl reads zero");
      idle();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog: run did not finish, act=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule